// File: doc/BRIEF.md
# Power-Up Strap Capture and Power-Down Sequencer

This block governs the operating mode of a clock generator around one shared control pin. While the device sits in its latches-open state, the first high level seen on the pin captures the configuration straps: the frequency-select code, the SRC5 pair enable, the ITP pair enable and the test-select strap. After that capture the same pin becomes an active-low power-down request. A low level parks the outputs. A high level brings them back.

When the pin returns high, a stored restore bit decides what happens. If it is set, the configuration survives and the outputs resume at once. If it is clear, the block issues a one-cycle wipe pulse that returns the register file to its defaults, re-enters the latches-open state and captures the straps again. An active management-mode flag forces the restore behaviour.

Test mode can be entered from the latched test-select strap or from a register entry bit. Once entered it holds until the next power cycle, which is `rst_n`. In test mode the outputs are either high-impedance or driven from the divided reference. With the strap, the live test-mode pin picks between the two. With the register path, a register select bit picks. Threshold detection on the analog pins is outside the block, so every pin arrives here as a digital level. The pin and the live test-mode input each pass through a synchronizer.

Top module: `pwrseq_top`

## Requirements
- R1: Until the straps are captured, `straps_valid` is 0 and `out_mode` is OFF (2'b00). The straps are captured from the strap inputs when the synchronized pin is seen high in the latches-open state. While `straps_valid` stays 1, `fs_sel_q` does not follow later changes of the strap inputs.
- R2: `itp_pair_sel` equals the captured ITP strap (1 = ITP pair, 0 = SRC8 pair). `src5_pair_sel` equals the captured SRC5 strap (1 = SRC5 pair, 0 = stop-pin functions).
- R3: After capture, a low level on the pin gives `out_mode` OFF (2'b00). When the pin goes high again, `out_mode` becomes NORMAL (2'b01).
- R4: On power-down exit with `restore_en` = 1, the captured straps are kept and `cfg_wipe` does not pulse.
- R5: On power-down exit with `restore_en` = 0 and `amt_active` = 0, `cfg_wipe` pulses for exactly one cycle and the straps present at that time are captured again.
- R6: When `amt_active` is 1, power-down exit behaves as with `restore_en` = 1, whatever the value of `restore_en`.
- R7: `se1_run` is 1 in NORMAL mode. In OFF mode `se1_run` equals `wol_en`. In test mode `se1_run` is 0.
- R8: If the test-select strap is captured as 1, `out_mode` becomes HIZ (2'b10) when the live `test_mode_pin` is 0 and REFN (2'b11) when it is 1.
- R9: If the test-select strap is captured as 0, setting `test_entry_reg` while running enters test mode. `test_refn_reg` then picks HIZ (0) or REFN (1), and `test_mode_pin` is ignored.
- R10: Test mode persists through `test_entry_reg` falling, through power-down and through a configuration wipe, and it takes priority over OFF. Only `rst_n` leaves test mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-cycle reset |
| pwrgd_pd_n | input | 1 | Shared pin: power-good on first rise, active-low power-down afterwards |
| fs_strap | input | FS_W | Frequency-select strap levels |
| src5_strap | input | 1 | SRC5 pair enable strap |
| itp_strap | input | 1 | ITP pair enable strap |
| tsel_strap | input | 1 | Test-select strap |
| test_mode_pin | input | 1 | Live Hi-Z/REFN pick used with strap-entered test mode |
| restore_en | input | 1 | Register bit: keep configuration over power-down |
| amt_active | input | 1 | Management mode active; forces restore |
| test_entry_reg | input | 1 | Register test-entry bit |
| test_refn_reg | input | 1 | Register Hi-Z/REFN pick |
| wol_en | input | 1 | Register bit: keep the 25 MHz output running while off |
| fs_sel_q | output | FS_W | Captured frequency select |
| src5_pair_sel | output | 1 | Captured SRC5 selection |
| itp_pair_sel | output | 1 | Captured ITP selection |
| straps_valid | output | 1 | Straps captured |
| out_mode | output | 2 | 00 OFF, 01 NORMAL, 10 HIZ, 11 REFN |
| se1_run | output | 1 | 25 MHz output runs |
| cfg_wipe | output | 1 | One-cycle pulse that resets the register file |

## Verification
The pin's return to high can both end a power-down and, when the restore is not in force, trigger a wipe and a new strap capture one cycle later. The bench changes the strap inputs during each power-down so that a capture that should not happen becomes visible. It draws random combinations of `restore_en` and `amt_active` and judges the retained or recaptured strap values, together with the count of wipe pulses, against its own model. Test entry is also combined with power-down and with a wipe, to show that test mode keeps its priority over OFF.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
    typedef enum logic [1:0] {
        ST_OPEN = 2'd0,
        ST_RUN  = 2'd1,
        ST_DOWN = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_NORMAL = 2'b01,
        MODE_HIZ    = 2'b10,
        MODE_REFN   = 2'b11
    } out_mode_e;
endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pwrseq_test_ctl.sv
module pwrseq_test_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic latch_ev,
    input  logic tsel_strap,
    input  logic running,
    input  logic reg_entry,
    input  logic reg_refn,
    input  logic live_refn,
    output logic test_on,
    output logic test_refn
);
    typedef struct packed {
        logic tsel;
        logic on;
    } test_reg_t;

    test_reg_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (latch_ev) begin
            t_d.tsel = tsel_strap;
            if (tsel_strap) t_d.on = 1'b1;
        end
        // register path only when the strap did not select test
        if (running && reg_entry && !t_q.tsel) t_d.on = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign test_on   = t_q.on;
    assign test_refn = t_q.tsel ? live_refn : reg_refn;
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
    import pwrseq_pkg::*;
#(
    parameter int FS_W        = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwrgd_pd_n,
    input  logic [FS_W-1:0] fs_strap,
    input  logic            src5_strap,
    input  logic            itp_strap,
    input  logic            tsel_strap,
    input  logic            test_mode_pin,
    input  logic            restore_en,
    input  logic            amt_active,
    input  logic            test_entry_reg,
    input  logic            test_refn_reg,
    input  logic            wol_en,
    output logic [FS_W-1:0] fs_sel_q,
    output logic            src5_pair_sel,
    output logic            itp_pair_sel,
    output logic            straps_valid,
    output logic [1:0]      out_mode,
    output logic            se1_run,
    output logic            cfg_wipe
);
    localparam int SYNC_W = 2;

    typedef struct packed {
        seq_state_e      state;
        logic [FS_W-1:0] fs;
        logic            src5;
        logic            itp;
        logic            valid;
        out_mode_e       mode;
        logic            se1;
        logic            wipe;
    } seq_reg_t;

    seq_reg_t           s_d, s_q;
    logic [SYNC_W-1:0]  sync_v;
    logic               pin_s, live_refn_s;
    logic               latch_ev, restore_eff;
    logic               test_on, test_refn;

    pwrseq_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({test_mode_pin, pwrgd_pd_n}),
        .sync_o  (sync_v)
    );
    assign pin_s       = sync_v[0];
    assign live_refn_s = sync_v[1];

    pwrseq_test_ctl i_test (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_ev  (latch_ev),
        .tsel_strap(tsel_strap),
        .running   (s_q.state == ST_RUN),
        .reg_entry (test_entry_reg),
        .reg_refn  (test_refn_reg),
        .live_refn (live_refn_s),
        .test_on   (test_on),
        .test_refn (test_refn)
    );

    always_comb begin
        s_d         = s_q;
        s_d.wipe    = 1'b0;
        latch_ev    = 1'b0;
        restore_eff = restore_en | amt_active;

        case (s_q.state)
            ST_OPEN: begin
                if (pin_s) begin
                    latch_ev  = 1'b1;
                    s_d.fs    = fs_strap;
                    s_d.src5  = src5_strap;
                    s_d.itp   = itp_strap;
                    s_d.valid = 1'b1;
                    s_d.state = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!pin_s) s_d.state = ST_DOWN;
            end
            ST_DOWN: begin
                if (pin_s) begin
                    if (restore_eff) begin
                        s_d.state = ST_RUN;
                    end else begin
                        s_d.state = ST_OPEN;
                        s_d.valid = 1'b0;
                        s_d.wipe  = 1'b1;
                    end
                end
            end
            default: s_d.state = ST_OPEN;
        endcase

        // test mode outranks both running and off
        if (test_on)                  s_d.mode = test_refn ? MODE_REFN : MODE_HIZ;
        else if (s_d.state == ST_RUN) s_d.mode = MODE_NORMAL;
        else                          s_d.mode = MODE_OFF;

        s_d.se1 = (s_d.mode == MODE_NORMAL) | ((s_d.mode == MODE_OFF) & wol_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_OPEN;
            s_q.mode  <= MODE_OFF;
        end else begin
            s_q <= s_d;
        end
    end

    assign fs_sel_q      = s_q.fs;
    assign src5_pair_sel = s_q.src5;
    assign itp_pair_sel  = s_q.itp;
    assign straps_valid  = s_q.valid;
    assign out_mode      = s_q.mode;
    assign se1_run       = s_q.se1;
    assign cfg_wipe      = s_q.wipe;
endmodule

// File: rtl/pwrseq_checker.sv
module pwrseq_checker #(
    parameter int FS_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [FS_W-1:0] fs_sel_q,
    input logic            straps_valid,
    input logic [1:0]      out_mode,
    input logic            se1_run,
    input logic            cfg_wipe,
    input logic            wol_en
);
    AST_NORMAL_NEEDS_STRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == 2'b01) |-> straps_valid); // R1

    AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (straps_valid && $past(straps_valid)) |-> $stable(fs_sel_q)); // R1

    AST_WIPE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wipe |=> !cfg_wipe); // R5

    AST_WIPE_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wipe |-> !straps_valid); // R5

    AST_SE1_OFF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_mode == 2'b00) && !$past(wol_en)) |-> !se1_run); // R7

    AST_SE1_TEST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_mode[1] |-> !se1_run); // R7

    AST_TEST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(out_mode[1]) |-> out_mode[1]); // R10
endmodule

bind pwrseq_top pwrseq_checker #(.FS_W(FS_W)) i_pwrseq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .fs_sel_q    (fs_sel_q),
    .straps_valid(straps_valid),
    .out_mode    (out_mode),
    .se1_run     (se1_run),
    .cfg_wipe    (cfg_wipe),
    .wol_en      (wol_en)
);

// File: tb/test_pwrseq_top.sv
module test_pwrseq_top;
    localparam int CLK_P = 10;
    localparam int FS_W  = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pwrgd_pd_n = 1'b0;
    logic [FS_W-1:0] fs_strap = '0;
    logic            src5_strap = 1'b0, itp_strap = 1'b0, tsel_strap = 1'b0;
    logic            test_mode_pin = 1'b0, restore_en = 1'b0, amt_active = 1'b0;
    logic            test_entry_reg = 1'b0, test_refn_reg = 1'b0, wol_en = 1'b0;
    logic [FS_W-1:0] fs_sel_q;
    logic            src5_pair_sel, itp_pair_sel, straps_valid, se1_run, cfg_wipe;
    logic [1:0]      out_mode;

    int n_tests = 0;
    int n_fail  = 0;
    int wipes   = 0;
    bit done    = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pwrseq_top #(.FS_W(FS_W)) i_pwrseq_top (
        .clk(clk), .rst_n(rst_n), .pwrgd_pd_n(pwrgd_pd_n), .fs_strap(fs_strap),
        .src5_strap(src5_strap), .itp_strap(itp_strap), .tsel_strap(tsel_strap),
        .test_mode_pin(test_mode_pin), .restore_en(restore_en), .amt_active(amt_active),
        .test_entry_reg(test_entry_reg), .test_refn_reg(test_refn_reg), .wol_en(wol_en),
        .fs_sel_q(fs_sel_q), .src5_pair_sel(src5_pair_sel), .itp_pair_sel(itp_pair_sel),
        .straps_valid(straps_valid), .out_mode(out_mode), .se1_run(se1_run),
        .cfg_wipe(cfg_wipe)
    );

    always @(negedge clk) if (rst_n && cfg_wipe) wipes++;

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int exp_se1(input int mode, input bit wol);
        if (mode == 1) return 1;
        if (mode == 0) return int'(wol);
        return 0;
    endfunction

    task automatic power_cycle();
        @(negedge clk);
        rst_n = 1'b0; pwrgd_pd_n = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [FS_W-1:0] e_fs;
        bit e_src5, e_itp;
        void'($urandom(32'h5eed_0042));

        power_cycle();
        cyc(4);
        chk("R1 valid before capture", straps_valid, 0);
        chk("R1 mode before capture", out_mode, 0);

        fs_strap = 3'd5; src5_strap = 1'b1; itp_strap = 1'b0;
        pwrgd_pd_n = 1'b1;
        cyc(6);
        chk("R1 valid", straps_valid, 1);
        chk("R1 fs captured", fs_sel_q, 5);
        chk("R2 src5", src5_pair_sel, 1);
        chk("R2 itp", itp_pair_sel, 0);
        chk("R3 normal", out_mode, 1);
        chk("R7 se1 normal", se1_run, 1);
        e_fs = 3'd5; e_src5 = 1'b1; e_itp = 1'b0;

        fs_strap = 3'd2; itp_strap = 1'b1;
        cyc(4);
        chk("R1 strap hold", fs_sel_q, 5);
        chk("R2 itp hold", itp_pair_sel, 0);

        for (int it = 0; it < 40; it++) begin
            logic [FS_W-1:0] nf;
            bit ns, ni, w, rs, am;
            int w0;
            nf = FS_W'($urandom); ns = 1'($urandom); ni = 1'($urandom);
            w = 1'($urandom); rs = 1'($urandom); am = 1'($urandom);
            if (it == 0) begin rs = 1'b0; am = 1'b1; end
            if (it == 1) begin rs = 1'b0; am = 1'b0; end
            wol_en = w;
            pwrgd_pd_n = 1'b0;
            cyc(6);
            chk("R3 off", out_mode, 0);
            chk("R7 se1 off", se1_run, exp_se1(0, w));
            fs_strap = nf; src5_strap = ns; itp_strap = ni;
            restore_en = rs; amt_active = am;
            w0 = wipes;
            pwrgd_pd_n = 1'b1;
            cyc(8);
            chk("R3 back to normal", out_mode, 1);
            if (rs || am) begin
                chk(am && !rs ? "R6 kept fs" : "R4 kept fs", fs_sel_q, e_fs);
                chk(am && !rs ? "R6 no wipe" : "R4 no wipe", wipes - w0, 0);
                chk("R4 kept src5", src5_pair_sel, e_src5);
            end else begin
                e_fs = nf; e_src5 = ns; e_itp = ni;
                chk("R5 one wipe", wipes - w0, 1);
                chk("R5 fs recaptured", fs_sel_q, e_fs);
                chk("R2 src5 recaptured", src5_pair_sel, e_src5);
                chk("R2 itp recaptured", itp_pair_sel, e_itp);
            end
            chk("R7 se1 normal", se1_run, 1);
        end

        // strap-entered test mode
        tsel_strap = 1'b1; test_mode_pin = 1'b0; restore_en = 1'b0; amt_active = 1'b0;
        power_cycle();
        pwrgd_pd_n = 1'b1;
        cyc(6);
        chk("R8 hiz", out_mode, 2);
        chk("R7 se1 test", se1_run, 0);
        test_mode_pin = 1'b1;
        cyc(5);
        chk("R8 refn", out_mode, 3);
        pwrgd_pd_n = 1'b0;
        cyc(6);
        chk("R10 test over off", out_mode, 3);
        pwrgd_pd_n = 1'b1;
        cyc(8);
        chk("R10 test through wipe", out_mode, 3);

        // register-entered test mode
        tsel_strap = 1'b0; test_mode_pin = 1'b1;
        power_cycle();
        chk("R10 left by power cycle", out_mode, 0);
        pwrgd_pd_n = 1'b1;
        cyc(6);
        chk("R9 normal before entry", out_mode, 1);
        test_refn_reg = 1'b0; test_entry_reg = 1'b1;
        cyc(4);
        chk("R9 reg hiz, pin ignored", out_mode, 2);
        test_refn_reg = 1'b1;
        cyc(3);
        chk("R9 reg refn", out_mode, 3);
        test_mode_pin = 1'b0;
        cyc(5);
        chk("R9 pin ignored", out_mode, 3);
        test_entry_reg = 1'b0;
        cyc(3);
        chk("R10 sticky after entry drop", out_mode, 3);
        pwrgd_pd_n = 1'b0;
        cyc(6);
        chk("R10 reg test over off", out_mode, 3);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule